// File: doc/BRIEF.md
# Asynchronous External-Memory Access Sequencer

This block turns a one-cycle host request into a complete asynchronous cycle on an external SRAM or NOR-type device. The host names one of several banks, a direction, an address and (for writes) the data. The sequencer then walks through programmable phases: address setup, an address hold phase when address and data share the bus, a data phase, and an optional bus turnaround gap. Each phase length is counted in clock cycles. When the last phase ends, it returns a one-cycle completion pulse, and the read data for a read.

Each bank has its own configuration inputs: an enable, a write permit, a shared address/data bus mode, an external data width of 8, 16 or 32 bits, and four phase lengths. The configuration is taken when a request is accepted and held for the whole access. An external wait input can stretch the data phase. It passes through a two-stage synchronizer, and its active level is selectable. The data bus is presented as separate output, per-byte-lane output-enable and input vectors, so the pad ring can build the tri-state buffer.

Top module: `xmem_async_seq`

## Requirements
- R1: After reset every chip select, output enable, write enable and address-valid strobe is high (inactive), all data lane enables are 0, and the done and reject pulses are 0.
- R2: A read to a separate-bus bank with setup length A (1..15) and data length D (1..255) asserts its chip select for A+D cycles. Output enable is low for the last D of them only. Done is high exactly A+D cycles after the accepting clock edge.
- R3: A setup length of 0 skips the address setup phase: address-valid never goes low, and done follows D cycles after acceptance.
- R4: On a shared-bus bank, an address hold phase of H (1..15) cycles follows setup. During setup and hold the address is driven on the data lanes of the bank's width, and address-valid is low during setup only.
- R5: On a shared-bus bank, a turnaround gap of T (0..15) cycles follows the data phase, with all strobes inactive, and delays done by T. On a separate-bus bank the programmed T has no effect on timing.
- R6: A request to a bank whose enable is 0 starts no cycle. Chip selects stay high, and a one-cycle reject pulse appears one cycle after the request edge.
- R7: A write to a bank whose write permit is 0 is refused in the same way, and write enable never goes low. Reads to that bank still complete normally.
- R8: On a write, write enable is low for exactly the D data-phase cycles and never together with output enable. On a separate-bus bank, the data lanes are driven only during those cycles, carrying the write data.
- R9: Width code 0 uses byte lane 0 (8 bits), code 1 uses lanes 0-1 (16 bits), and codes 2 and 3 use all four lanes (32 bits). Read data above the selected width returns as zero.
- R10: Read data is the bus value present at the clock edge that ends the last data-phase cycle. Output enable rises at that same edge, and the sequencer never drives a lane while output enable is low.
- R11: With wait enabled, a synchronized wait input at its active level (selected by the polarity input: 1 = active high, 0 = active low) freezes the data-phase count. After release the phase completes its remaining count. With wait disabled the input has no effect.
- R12: Done is a single-cycle pulse. The sequencer is idle for at least one cycle after done, and a request held high throughout is accepted again only in the cycle after that idle cycle.
- R13: Only the chip select of the addressed bank goes low, and the access uses that bank's own phase lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Request, sampled while idle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_bank | input | 2 | Bank number |
| host_addr | input | 24 | Access address |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, held until the next read |
| host_done | output | 1 | One-cycle completion pulse |
| host_rej | output | 1 | One-cycle refusal pulse |
| cfg_en | input | 4 | Per-bank enable |
| cfg_wr_ok | input | 4 | Per-bank write permit |
| cfg_mux | input | 4 | Per-bank shared address/data bus mode |
| cfg_width | input | 8 | Per-bank 2-bit width code |
| cfg_aset | input | 16 | Per-bank 4-bit address setup length |
| cfg_ahld | input | 16 | Per-bank 4-bit address hold length |
| cfg_dset | input | 32 | Per-bank 8-bit data phase length |
| cfg_turn | input | 16 | Per-bank 4-bit turnaround length |
| wait_en | input | 1 | Enables the wait input |
| wait_pol | input | 1 | Active level of the wait input |
| mem_wait | input | 1 | Asynchronous wait from the device |
| mem_cs_n | output | 4 | Per-bank chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_addr | output | 24 | Address bus |
| mem_dq_out | output | 32 | Data bus output value |
| mem_dq_oe | output | 4 | Per-byte-lane output enable |
| mem_dq_in | input | 32 | Data bus input value |

## Verification
Every pin is a register whose value is decoded from the phase entered at a clock edge. A phase that starts at edge k is therefore visible from just after edge k. Done appears A+H+D+T edges after the accepting edge, the reject pulse one edge after the request, and a wait release takes effect three edges later: two synchronizer stages plus the edge that sees the change. The bench samples every output on the falling edge and counts falling edges from the accepting edge. It tallies strobe-low cycles and the first output-enable cycle against these sums. For a read it places a different value on the bus before every edge, so the value that must appear in the read data identifies the single edge that captured it.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  localparam int SETW  = 4;
  localparam int HOLDW = 4;
  localparam int DATW  = 8;
  localparam int TURNW = 4;
  localparam int CNTW  = 8;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ASET, PH_AHLD, PH_DATA, PH_TURN, PH_DONE
  } ph_e;

  // timing and bus shape held for the duration of one access
  typedef struct packed {
    logic             mux;
    logic [1:0]       width;
    logic [SETW-1:0]  aset;
    logic [HOLDW-1:0] ahld;
    logic [DATW-1:0]  dset;
    logic [TURNW-1:0] turn;
  } bank_tim_t;

  typedef struct packed {
    logic      en;
    logic      wr_ok;
    bank_tim_t tim;
  } bank_cfg_t;
endpackage

// File: rtl/xmem_cfg_mux.sv
module xmem_cfg_mux
  import xmem_pkg::*;
#(
  parameter int NBANK = 4
) (
  input  logic [NBANK-1:0]       en,
  input  logic [NBANK-1:0]       wr_ok,
  input  logic [NBANK-1:0]       mux,
  input  logic [2*NBANK-1:0]     width,
  input  logic [SETW*NBANK-1:0]  aset,
  input  logic [HOLDW*NBANK-1:0] ahld,
  input  logic [DATW*NBANK-1:0]  dset,
  input  logic [TURNW*NBANK-1:0] turn,
  input  logic [$clog2(NBANK)-1:0] sel,
  output bank_cfg_t              cfg
);
  bank_cfg_t tbl [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    assign tbl[g] = {en[g], wr_ok[g], mux[g], width[2*g +: 2],
                     aset[SETW*g +: SETW], ahld[HOLDW*g +: HOLDW],
                     dset[DATW*g +: DATW], turn[TURNW*g +: TURNW]};
  end

  assign cfg = tbl[sel];
endmodule

// File: rtl/xmem_wait_sync.sv
module xmem_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic wait_in,
  input  logic wait_en,
  input  logic wait_pol,
  output logic w_act
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-2:0], wait_in};
  end

  assign w_act = wait_en && (sr[STAGES-1] == wait_pol);
endmodule

// File: rtl/xmem_phase_fsm.sv
module xmem_phase_fsm
  import xmem_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int AW    = 24,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req,
  input  logic                     we,
  input  logic [$clog2(NBANK)-1:0] bank,
  input  logic [AW-1:0]            addr,
  input  logic [DW-1:0]            wdata,
  input  bank_cfg_t                sel_cfg,
  input  logic                     w_act,
  output ph_e                      st_d,
  output bank_tim_t                tim_d,
  output logic [$clog2(NBANK)-1:0] bank_d,
  output logic                     wr_d,
  output logic [AW-1:0]            addr_d,
  output logic [DW-1:0]            wdat_d,
  output logic                     cap,
  output logic                     rej_d
);
  ph_e                      st_q;
  logic [CNTW-1:0]          cnt_q, cnt_d;
  bank_tim_t                tim_q;
  logic [$clog2(NBANK)-1:0] bank_q;
  logic                     wr_q;
  logic [AW-1:0]            addr_q;
  logic [DW-1:0]            wdat_q;

  function automatic ph_e next_ph(ph_e cur, bank_tim_t t);
    ph_e n;
    n = PH_DONE;
    case (cur)
      PH_IDLE: if (t.aset != '0) n = PH_ASET;
               else if (t.mux)   n = PH_AHLD;
               else              n = PH_DATA;
      PH_ASET: if (t.mux) n = PH_AHLD;
               else       n = PH_DATA;
      PH_AHLD: n = PH_DATA;
      PH_DATA: if (t.mux && t.turn != '0) n = PH_TURN;
               else                       n = PH_DONE;
      default: n = PH_DONE;
    endcase
    return n;
  endfunction

  // zero lengths on hold and data phases are raised to one cycle
  function automatic logic [CNTW-1:0] ph_len(ph_e p, bank_tim_t t);
    logic [CNTW-1:0] l;
    case (p)
      PH_ASET: l = CNTW'(t.aset);
      PH_AHLD: l = (t.ahld == '0) ? CNTW'(1) : CNTW'(t.ahld);
      PH_DATA: l = (t.dset == '0) ? CNTW'(1) : CNTW'(t.dset);
      PH_TURN: l = CNTW'(t.turn);
      default: l = '0;
    endcase
    return l;
  endfunction

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    tim_d  = tim_q;
    bank_d = bank_q;
    wr_d   = wr_q;
    addr_d = addr_q;
    wdat_d = wdat_q;
    rej_d  = 1'b0;
    cap    = 1'b0;
    case (st_q)
      PH_IDLE: begin
        if (req) begin
          if (!sel_cfg.en || (we && !sel_cfg.wr_ok)) begin
            rej_d = 1'b1;
          end else begin
            tim_d  = sel_cfg.tim;
            bank_d = bank;
            wr_d   = we;
            addr_d = addr;
            wdat_d = wdata;
            st_d   = next_ph(PH_IDLE, sel_cfg.tim);
            cnt_d  = ph_len(st_d, sel_cfg.tim);
          end
        end
      end
      PH_DONE: st_d = PH_IDLE;
      default: begin
        if (!(st_q == PH_DATA && w_act)) begin
          if (cnt_q <= CNTW'(1)) begin
            st_d  = next_ph(st_q, tim_q);
            cnt_d = ph_len(st_d, tim_q);
            cap   = (st_q == PH_DATA) && !wr_q;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= PH_IDLE;
      cnt_q  <= '0;
      tim_q  <= '0;
      bank_q <= '0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      wdat_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      tim_q  <= tim_d;
      bank_q <= bank_d;
      wr_q   <= wr_d;
      addr_q <= addr_d;
      wdat_q <= wdat_d;
    end
  end

  AST_DATA_CNT_LIVE: assert property (@(posedge clk) disable iff (rst)
    (st_q == PH_DATA) |-> (cnt_q != '0)); // R2
  AST_WAIT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (st_q == PH_DATA && w_act) |=> (st_q == PH_DATA && $stable(cnt_q))); // R11
  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (st_q == PH_DONE) |=> (st_q == PH_IDLE)); // R12
endmodule

// File: rtl/xmem_pin_drv.sv
module xmem_pin_drv
  import xmem_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int AW    = 24,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  ph_e                      st_d,
  input  logic                     mux_d,
  input  logic [1:0]               width_d,
  input  logic [$clog2(NBANK)-1:0] bank_d,
  input  logic                     wr_d,
  input  logic [AW-1:0]            addr_d,
  input  logic [DW-1:0]            wdat_d,
  input  logic                     cap,
  input  logic                     rej_d,
  input  logic [DW-1:0]            dq_in,
  output logic [NBANK-1:0]         cs_n,
  output logic                     oe_n,
  output logic                     we_n,
  output logic                     adv_n,
  output logic [AW-1:0]            mem_addr,
  output logic [DW-1:0]            dq_out,
  output logic [DW/8-1:0]          dq_oe,
  output logic [DW-1:0]            rdata,
  output logic                     done,
  output logic                     rej
);
  localparam int LANES = DW / 8;

  logic [LANES-1:0] lane_on;
  logic [DW-1:0]    bmask;
  logic             busy, addr_ph, wr_ph, rd_ph;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_on[g]       = (g < (1 << width_d));
    assign bmask[8*g +: 8]  = {8{lane_on[g]}};
  end

  always_comb begin
    busy    = (st_d == PH_ASET) || (st_d == PH_AHLD) || (st_d == PH_DATA);
    addr_ph = mux_d && ((st_d == PH_ASET) || (st_d == PH_AHLD));
    wr_ph   = (st_d == PH_DATA) && wr_d;
    rd_ph   = (st_d == PH_DATA) && !wr_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n     <= '1;
      oe_n     <= 1'b1;
      we_n     <= 1'b1;
      adv_n    <= 1'b1;
      mem_addr <= '0;
      dq_out   <= '0;
      dq_oe    <= '0;
      rdata    <= '0;
      done     <= 1'b0;
      rej      <= 1'b0;
    end else begin
      cs_n     <= busy ? ~(NBANK'(1) << bank_d) : '1;
      oe_n     <= !rd_ph;
      we_n     <= !wr_ph;
      adv_n    <= !(st_d == PH_ASET);
      mem_addr <= addr_d;
      dq_oe    <= (addr_ph || wr_ph) ? lane_on : '0;
      if (wr_ph)        dq_out <= wdat_d & bmask;
      else if (addr_ph) dq_out <= DW'(addr_d) & bmask;
      else              dq_out <= '0;
      if (cap) rdata <= dq_in & bmask;
      done     <= (st_d == PH_DONE);
      rej      <= rej_d;
    end
  end

  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!we_n && !oe_n)); // R8
  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (rst)
    (!we_n || !oe_n) |-> (cs_n != '1)); // R2
  AST_ONE_CS: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n)); // R13
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R12
  AST_BUS_FREE_READ: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> (dq_oe == '0)); // R10
  AST_REJ_IDLE: assert property (@(posedge clk) disable iff (rst)
    rej |-> (cs_n == '1 && !done)); // R6
endmodule

// File: rtl/xmem_async_seq.sv
module xmem_async_seq
  import xmem_pkg::*;
#(
  parameter int NBANK       = 4,
  parameter int AW          = 24,
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       host_req,
  input  logic                       host_we,
  input  logic [$clog2(NBANK)-1:0]   host_bank,
  input  logic [AW-1:0]              host_addr,
  input  logic [DW-1:0]              host_wdata,
  output logic [DW-1:0]              host_rdata,
  output logic                       host_done,
  output logic                       host_rej,
  input  logic [NBANK-1:0]           cfg_en,
  input  logic [NBANK-1:0]           cfg_wr_ok,
  input  logic [NBANK-1:0]           cfg_mux,
  input  logic [2*NBANK-1:0]         cfg_width,
  input  logic [SETW*NBANK-1:0]      cfg_aset,
  input  logic [HOLDW*NBANK-1:0]     cfg_ahld,
  input  logic [DATW*NBANK-1:0]      cfg_dset,
  input  logic [TURNW*NBANK-1:0]     cfg_turn,
  input  logic                       wait_en,
  input  logic                       wait_pol,
  input  logic                       mem_wait,
  output logic [NBANK-1:0]           mem_cs_n,
  output logic                       mem_oe_n,
  output logic                       mem_we_n,
  output logic                       mem_adv_n,
  output logic [AW-1:0]              mem_addr,
  output logic [DW-1:0]              mem_dq_out,
  output logic [DW/8-1:0]            mem_dq_oe,
  input  logic [DW-1:0]              mem_dq_in
);
  bank_cfg_t                sel_cfg;
  bank_tim_t                tim_d;
  ph_e                      st_d;
  logic [$clog2(NBANK)-1:0] bank_d;
  logic                     w_act, wr_d, cap, rej_d;
  logic [AW-1:0]            addr_d;
  logic [DW-1:0]            wdat_d;

  xmem_cfg_mux #(.NBANK(NBANK)) u_cfg (
    .en(cfg_en), .wr_ok(cfg_wr_ok), .mux(cfg_mux), .width(cfg_width),
    .aset(cfg_aset), .ahld(cfg_ahld), .dset(cfg_dset), .turn(cfg_turn),
    .sel(host_bank), .cfg(sel_cfg)
  );

  xmem_wait_sync #(.STAGES(SYNC_STAGES)) u_wait (
    .clk(clk), .rst(rst), .wait_in(mem_wait), .wait_en(wait_en),
    .wait_pol(wait_pol), .w_act(w_act)
  );

  xmem_phase_fsm #(.NBANK(NBANK), .AW(AW), .DW(DW)) u_fsm (
    .clk(clk), .rst(rst), .req(host_req), .we(host_we), .bank(host_bank),
    .addr(host_addr), .wdata(host_wdata), .sel_cfg(sel_cfg), .w_act(w_act),
    .st_d(st_d), .tim_d(tim_d), .bank_d(bank_d), .wr_d(wr_d),
    .addr_d(addr_d), .wdat_d(wdat_d), .cap(cap), .rej_d(rej_d)
  );

  xmem_pin_drv #(.NBANK(NBANK), .AW(AW), .DW(DW)) u_pin (
    .clk(clk), .rst(rst), .st_d(st_d), .mux_d(tim_d.mux),
    .width_d(tim_d.width), .bank_d(bank_d), .wr_d(wr_d), .addr_d(addr_d),
    .wdat_d(wdat_d), .cap(cap), .rej_d(rej_d), .dq_in(mem_dq_in),
    .cs_n(mem_cs_n), .oe_n(mem_oe_n), .we_n(mem_we_n), .adv_n(mem_adv_n),
    .mem_addr(mem_addr), .dq_out(mem_dq_out), .dq_oe(mem_dq_oe),
    .rdata(host_rdata), .done(host_done), .rej(host_rej)
  );
endmodule

// File: tb/tb_xmem_async_seq.sv
`timescale 1ns/1ps
module tb_xmem_async_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  bank = '0;
  logic [23:0] addr = '0;
  logic [31:0] wdata = '0, rdata, dq_out, dq_in = '0;
  logic        done, rej, oe_n, we_n, adv_n;
  logic [3:0]  cs_n, dq_oe;
  logic [23:0] maddr;
  logic [3:0]  cfg_en = '0, cfg_wr_ok = '0, cfg_mux = '0;
  logic [7:0]  cfg_width = '0;
  logic [15:0] cfg_aset = '0, cfg_ahld = '0, cfg_turn = '0;
  logic [31:0] cfg_dset = '0;
  logic        wait_en = 1'b0, wait_pol = 1'b1, wait_in = 1'b0;

  int n_chk = 0, n_fail = 0;
  int o_done, o_cs, o_cswrong, o_oe, o_first_oe, o_we, o_adv, o_drv;
  logic [31:0] o_wd, o_ad;
  logic [3:0]  o_lanes;
  bit   hold_req = 0;
  int   rel_at = -1;
  logic rel_val = 1'b0;

  always #2 clk = ~clk;

  xmem_async_seq dut (
    .clk(clk), .rst(rst), .host_req(req), .host_we(we), .host_bank(bank),
    .host_addr(addr), .host_wdata(wdata), .host_rdata(rdata),
    .host_done(done), .host_rej(rej), .cfg_en(cfg_en), .cfg_wr_ok(cfg_wr_ok),
    .cfg_mux(cfg_mux), .cfg_width(cfg_width), .cfg_aset(cfg_aset),
    .cfg_ahld(cfg_ahld), .cfg_dset(cfg_dset), .cfg_turn(cfg_turn),
    .wait_en(wait_en), .wait_pol(wait_pol), .mem_wait(wait_in),
    .mem_cs_n(cs_n), .mem_oe_n(oe_n), .mem_we_n(we_n), .mem_adv_n(adv_n),
    .mem_addr(maddr), .mem_dq_out(dq_out), .mem_dq_oe(dq_oe), .mem_dq_in(dq_in)
  );

  function automatic logic [31:0] fpat(int c);
    return {8'(c + 64), 8'(c + 48), 8'(c + 32), 8'(c + 16)};
  endfunction

  function automatic logic [31:0] wmask(int w);
    return (w == 0) ? 32'h0000_00FF : (w == 1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  task automatic chk(string r, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic set_bank(int b, bit en, bit wok, bit mx, int w, int a, int h, int d, int t);
    cfg_en[b] = en; cfg_wr_ok[b] = wok; cfg_mux[b] = mx;
    cfg_width[2*b +: 2] = 2'(w);
    cfg_aset[4*b +: 4] = 4'(a); cfg_ahld[4*b +: 4] = 4'(h);
    cfg_dset[8*b +: 8] = 8'(d); cfg_turn[4*b +: 4] = 4'(t);
  endtask

  // observation c = falling edge after accepting edge + c
  task automatic do_access(int b, bit w, logic [23:0] a, logic [31:0] wd);
    @(negedge clk);
    bank = 2'(b); we = w; addr = a; wdata = wd; req = 1'b1; dq_in = fpat(-1);
    o_done = -1; o_cs = 0; o_cswrong = 0; o_oe = 0; o_first_oe = -1;
    o_we = 0; o_adv = 0; o_drv = 0; o_wd = 'x; o_ad = 'x; o_lanes = '0;
    @(posedge clk);
    @(negedge clk);
    if (!hold_req) req = 1'b0;
    for (int c = 0; c < 600; c++) begin
      if (rel_at == c) wait_in = rel_val;
      if (cs_n != 4'hF) begin
        o_cs++;
        if (cs_n != ~(4'b0001 << b)) o_cswrong++;
      end
      if (!oe_n) begin o_oe++; if (o_first_oe < 0) o_first_oe = c; end
      if (!we_n) begin o_we++; o_wd = dq_out; end
      if (!adv_n) begin o_adv++; o_ad = dq_out; end
      if (dq_oe != 4'h0) begin o_drv++; o_lanes = dq_oe; end
      if (done) begin o_done = c; break; end
      dq_in = fpat(c);
      @(negedge clk);
    end
    if (o_done < 0) chk("R2", "done never seen", 0, 1);
  endtask

  task automatic do_reject(string r, int b, bit w);
    @(negedge clk);
    bank = 2'(b); we = w; req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    chk(r, "reject pulse", {63'b0, rej}, 1);
    chk(r, "no chip select", {60'b0, cs_n}, 64'hF);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(r, "stays idle", {59'b0, rej, cs_n, we_n, done}, {59'b0, 1'b0, 4'hF, 1'b1, 1'b0});
    end
  endtask

  task automatic t_reset;
    chk("R1", "strobes", {57'b0, cs_n, oe_n, we_n, adv_n}, {57'b0, 4'hF, 3'b111});
    chk("R1", "lanes/pulses", {58'b0, dq_oe, done, rej}, 0);
  endtask

  task automatic t_read_sep;
    set_bank(0, 1, 1, 0, 2, 2, 1, 3, 0);
    do_access(0, 0, 24'h12_3456, '0);
    chk("R2", "done cycle", o_done, 5);
    chk("R2", "cs low cycles", o_cs, 5);
    chk("R2", "oe low cycles", o_oe, 3);
    chk("R2", "first oe", o_first_oe, 2);
    chk("R13", "wrong cs", o_cswrong, 0);
    chk("R10", "read data edge", rdata, fpat(4));
    chk("R10", "no drive on read", o_drv, 0);
    chk("R9", "address bus", {40'b0, maddr}, 64'h12_3456);
  endtask

  task automatic t_aset_zero;
    set_bank(1, 1, 1, 0, 1, 0, 1, 1, 0);
    do_access(1, 0, 24'h00_0777, '0);
    chk("R3", "done cycle", o_done, 1);
    chk("R3", "adv never low", o_adv, 0);
    chk("R9", "16-bit read zero-extended", rdata, fpat(0) & 32'h0000_FFFF);
  endtask

  task automatic t_write_sep;
    do_access(0, 1, 24'h00_0040, 32'hDEAD_BEEF);
    chk("R8", "done cycle", o_done, 5);
    chk("R8", "we low cycles", o_we, 3);
    chk("R8", "oe never low", o_oe, 0);
    chk("R8", "drive cycles", o_drv, 3);
    chk("R8", "write data", o_wd, 32'hDEAD_BEEF);
    chk("R9", "32-bit lanes", o_lanes, 4'hF);
  endtask

  task automatic t_mux;
    set_bank(2, 1, 1, 1, 1, 2, 3, 2, 4);
    do_access(2, 0, 24'h5A_3C7E, '0);
    chk("R5", "done with turnaround", o_done, 11);
    chk("R4", "cs low cycles", o_cs, 7);
    chk("R4", "adv low cycles", o_adv, 2);
    chk("R4", "address on lanes", o_ad, 32'h0000_3C7E);
    chk("R4", "address drive cycles", o_drv, 5);
    chk("R4", "first oe after hold", o_first_oe, 5);
    chk("R9", "16-bit lanes", o_lanes, 4'h3);
    chk("R10", "mux read data", rdata, fpat(6) & 32'h0000_FFFF);
    set_bank(3, 1, 1, 1, 0, 1, 1, 2, 0);
    do_access(3, 1, 24'h00_01A5, 32'h1122_3344);
    chk("R5", "zero turnaround", o_done, 4);
    chk("R4", "mux write drive cycles", o_drv, 4);
    chk("R9", "8-bit lanes", o_lanes, 4'h1);
    chk("R9", "8-bit write data", o_wd, 32'h0000_0044);
    chk("R4", "8-bit address", o_ad, 32'h0000_00A5);
  endtask

  task automatic t_turn_ignored;
    set_bank(0, 1, 1, 0, 2, 2, 1, 3, 7);
    do_access(0, 0, 24'h0, '0);
    chk("R5", "turn ignored without mux", o_done, 5);
  endtask

  task automatic t_refuse;
    set_bank(1, 0, 1, 0, 1, 0, 1, 1, 0);
    do_reject("R6", 1, 0);
    set_bank(1, 1, 1, 0, 1, 0, 1, 1, 0);
    set_bank(0, 1, 0, 0, 2, 2, 1, 3, 0);
    do_reject("R7", 0, 1);
    do_access(0, 0, 24'h0, '0);
    chk("R7", "read allowed when write barred", o_done, 5);
    set_bank(0, 1, 1, 0, 2, 2, 1, 3, 0);
  endtask

  task automatic t_wait;
    wait_en = 1; wait_pol = 1; wait_in = 1; rel_at = 20; rel_val = 0;
    do_access(0, 0, 24'h0, '0);
    chk("R11", "active-high wait", o_done, 25);
    wait_pol = 0; wait_in = 0; rel_val = 1;
    repeat (4) @(negedge clk);
    do_access(0, 0, 24'h0, '0);
    chk("R11", "active-low wait", o_done, 25);
    wait_en = 0; wait_in = 0; rel_at = -1;
    repeat (4) @(negedge clk);
    do_access(0, 0, 24'h0, '0);
    chk("R11", "wait disabled", o_done, 5);
    wait_in = 1; wait_pol = 1;
  endtask

  task automatic t_busy;
    bit seen = 0;
    hold_req = 1;
    do_access(1, 0, 24'h0, '0);
    chk("R12", "first done", o_done, 1);
    @(negedge clk);
    chk("R12", "idle after done", {59'b0, cs_n, done}, {59'b0, 4'hF, 1'b0});
    @(negedge clk);
    chk("R12", "re-accept", {63'b0, cs_n[1]}, 0);
    req = 0; hold_req = 0;
    for (int i = 0; i < 50; i++) begin
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
    chk("R12", "second done", {63'b0, seen}, 1);
  endtask

  task automatic t_bank_sel;
    set_bank(3, 1, 1, 0, 2, 1, 1, 6, 0);
    do_access(3, 0, 24'h0, '0);
    chk("R13", "bank 3 timing", o_done, 7);
    chk("R13", "bank 3 cs", o_cswrong, 0);
    do_access(0, 0, 24'h0, '0);
    chk("R13", "bank 0 timing", o_done, 5);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_read_sep();
    t_aset_zero();
    t_write_sep();
    t_mux();
    t_turn_ignored();
    t_refuse();
    t_wait();
    t_busy();
    t_bank_sel();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule